// File: doc/BRIEF.md
# Asynchronous Peripheral Configuration Byte Loader

This block lets a host processor push configuration bytes into a chip over a plain asynchronous bus. The host addresses the block with a pair of chip selects, puts a byte on an 8-bit data bus and pulses an active-low write strobe. Each accepted byte passes through a two-entry double buffer. The first entry is a hold register that takes the byte off the bus. The second is a shift register that sends the byte out one bit at a time as a serial stream. Serial bits leave at a pace set by a free-running serial clock enable, and a valid/ready handshake toward the downstream sink lets the sink slow them further.

The host paces itself with a ready/busy line. Busy is short when the shift register is idle and the byte drops straight through. Busy is long when the shift register has just started on the previous byte. The same status can be read back over the bus. With the block selected, write high and read low, bit 7 of the data bus is driven with the ready/busy level. The other seven data lines are never driven. An input option reverses the bit order of each byte, for hosts whose image has mirrored bit order. Writes that arrive while busy are dropped and recorded in a sticky overrun flag.

Top module: `cfg_byte_loader`

## Requirements
- R1: A write is taken only while `cs_n` is 0 and `cs` is 1. A strobe with either select inactive loads nothing and leaves `rdy` high. The selects may be held static or cycled around each byte.
- R2: Each accepted write produces exactly 8 serial beats on `ser_data`, most significant bit first, in the order the bytes were written.
- R3: If the shift register is idle, `rdy` goes low on the third rising clock edge after `wr_n` falls. It returns high on the next edge, so it is low for exactly one cycle.
- R4: If a byte reaches the hold register while the shift register is still busy, `rdy` stays low until the eighth beat of the earlier byte is accepted. It rises on the clock edge after that beat.
- R5: A write taken while `rdy` is low is dropped: its byte never appears on the serial output. `overrun` goes to 1 and stays there until reset.
- R6: While `cs_n`=0, `cs`=1, `wr_n`=1 and `rd_n`=0, `bus_oe` is 8'h80 and `bus_q[7]` equals `rdy`. At all other times `bus_oe[7]` is 0.
- R7: `bus_oe[6:0]` is always 0.
- R8: With `mirror_en`=1 at capture, bit i of the written byte is sent as bit 7-i. The reversed byte is still sent most significant bit first.
- R9: `ser_valid` rises only on a serial clock enable. Once `ser_valid` is high, it and `ser_data` hold steady until a cycle in which `ser_ready` is 1. A beat is consumed in each cycle where both are 1.
- R10: After reset, `rdy`=1, `overrun`=0, `ser_valid`=0 and `bus_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d_in | input | 8 | Host data bus, input side |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe (asynchronous) |
| rd_n | input | 1 | Active-low read strobe, output enable for bit 7 |
| mirror_en | input | 1 | Reverse the bit order of captured bytes |
| bus_q | output | 8 | Host data bus, output side (bit 7 only meaningful) |
| bus_oe | output | 8 | Per-bit drive enable for the host data bus |
| rdy | output | 1 | 1 = ready for a byte, 0 = busy |
| overrun | output | 1 | Sticky: a write arrived while busy |
| ser_data | output | 1 | Serial configuration bit |
| ser_valid | output | 1 | Serial bit is valid |
| ser_ready | input | 1 | Sink accepts the serial bit |

## Verification
A falling `wr_n` passes two synchronizer stages and one edge-detect register. The byte is therefore in the hold register after the third rising edge. The bench samples `rdy` at the falling edge after each of the following rising edges and expects the single low sample at the third. In the long-busy case, a monitor stamps the rising edge at which the eighth beat of the earlier byte was accepted, and `rdy` must be seen high at the falling edge that follows the very next rising edge. Bus readback is combinational from the pins, so it is checked at the falling edge in the same cycle the strobes change. The serial stream is rebuilt beat by beat and compared with a queue of expected bytes computed in the bench, including bit reversal.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  localparam int CFL_BYTE_W = 8;

  typedef logic [CFL_BYTE_W-1:0] cfl_byte_t;

  // one buffer slot: occupancy flag plus payload
  typedef struct packed {
    logic      full;
    cfl_byte_t data;
  } cfl_slot_t;
endpackage

// File: rtl/cfl_sync.sv
module cfl_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfl_front.sv
module cfl_front
  import cfl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  cfl_byte_t bus_d_in,
  input  logic      cs_n,
  input  logic      cs,
  input  logic      wr_n,
  input  logic      rd_n,
  input  logic      mirror_en,
  input  logic      status_bit,
  output logic      wr_pulse,
  output cfl_byte_t wr_byte,
  output cfl_byte_t bus_q,
  output cfl_byte_t bus_oe
);
  localparam int W = CFL_BYTE_W;

  // active-high forms of the asynchronous controls: {write, sel_lo, sel_hi}
  logic [2:0] ctl_raw, ctl_s;
  logic       wr_req, wr_req_q;
  cfl_byte_t  flipped;
  logic       rd_en;

  assign ctl_raw = {~wr_n, ~cs_n, cs};

  cfl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ctl_raw),
    .q     (ctl_s)
  );

  assign wr_req = ctl_s[2] & ctl_s[1] & ctl_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_req_q <= 1'b0;
    else        wr_req_q <= wr_req;
  end

  assign wr_pulse = wr_req & ~wr_req_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_flip
      assign flipped[i] = bus_d_in[W-1-i];
    end
  endgenerate

  assign wr_byte = mirror_en ? flipped : bus_d_in;

  // readback path straight from the pins: only the top bit may be driven
  assign rd_en  = ~cs_n & cs & wr_n & ~rd_n;
  assign bus_oe = {rd_en, {(W-1){1'b0}}};
  assign bus_q  = {status_bit, {(W-1){1'b0}}};
endmodule

// File: rtl/cfl_tick.sv
module cfl_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (cnt == 0) cnt <= CW'(DIV - 1);
    else               cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == 0);
endmodule

// File: rtl/cfl_dblbuf.sv
module cfl_dblbuf
  import cfl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_pulse,
  input  cfl_byte_t wr_byte,
  input  logic      tick,
  input  logic      ser_ready,
  output logic      rdy,
  output logic      overrun,
  output logic      ser_valid,
  output logic      ser_data
);
  localparam int W     = CFL_BYTE_W;
  localparam int CNT_W = $clog2(W + 1);

  cfl_slot_t       hold;
  cfl_byte_t       sreg;
  logic [CNT_W-1:0] left;
  logic            vld_q;
  logic            shift_idle, take, accept, drop;

  assign shift_idle = (left == '0) && !vld_q;
  assign take       = hold.full && shift_idle;
  assign accept     = vld_q && ser_ready;
  assign drop       = wr_pulse && hold.full;

  // hold register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (take) begin
      hold.full <= 1'b0;
    end else if (wr_pulse && !hold.full) begin
      hold.full <= 1'b1;
      hold.data <= wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    overrun <= 1'b0;
    else if (drop) overrun <= 1'b1;
  end

  // shift register and serial handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      left  <= '0;
      vld_q <= 1'b0;
    end else if (take) begin
      sreg <= hold.data;
      left <= CNT_W'(W);
    end else if (accept) begin
      sreg  <= {sreg[W-2:0], 1'b0};
      left  <= left - 1'b1;
      vld_q <= 1'b0;
    end else if (!vld_q && (left != '0) && tick) begin
      vld_q <= 1'b1;
    end
  end

  assign rdy       = ~hold.full;
  assign ser_valid = vld_q;
  assign ser_data  = sreg[W-1];
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
  import cfl_pkg::*;
#(
  parameter int SER_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_d_in,
  input  logic       cs_n,
  input  logic       cs,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       mirror_en,
  output logic [7:0] bus_q,
  output logic [7:0] bus_oe,
  output logic       rdy,
  output logic       overrun,
  output logic       ser_data,
  output logic       ser_valid,
  input  logic       ser_ready
);
  logic      wr_pulse;
  cfl_byte_t wr_byte;
  logic      tick;

  cfl_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_d_in   (bus_d_in),
    .cs_n       (cs_n),
    .cs         (cs),
    .wr_n       (wr_n),
    .rd_n       (rd_n),
    .mirror_en  (mirror_en),
    .status_bit (rdy),
    .wr_pulse   (wr_pulse),
    .wr_byte    (wr_byte),
    .bus_q      (bus_q),
    .bus_oe     (bus_oe)
  );

  cfl_tick #(.DIV(SER_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  cfl_dblbuf u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_pulse  (wr_pulse),
    .wr_byte   (wr_byte),
    .tick      (tick),
    .ser_ready (ser_ready),
    .rdy       (rdy),
    .overrun   (overrun),
    .ser_valid (ser_valid),
    .ser_data  (ser_data)
  );
endmodule

// File: rtl/cfl_checker.sv
module cfl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rdy,
  input logic       overrun,
  input logic       ser_valid,
  input logic       ser_ready,
  input logic       ser_data,
  input logic       d7_q,
  input logic [7:0] bus_oe
);
  AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid && !ser_ready |=> ser_valid && $stable(ser_data)); // R9

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R5

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(!rdy)); // R5

  AST_LOW_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe[6:0] == 7'd0); // R7

  AST_RDBK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe[7] && !rdy |-> !d7_q); // R6

  AST_LONG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy && ser_valid |=> !rdy); // R4
endmodule

bind cfg_byte_loader cfl_checker u_cfl_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .rdy       (rdy),
  .overrun   (overrun),
  .ser_valid (ser_valid),
  .ser_ready (ser_ready),
  .ser_data  (ser_data),
  .d7_q      (bus_q[7]),
  .bus_oe    (bus_oe)
);

// File: tb/test_cfg_byte_loader.sv
module test_cfg_byte_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_d_in = 8'h00;
  logic       cs_n = 1'b1, cs = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic       mirror_en = 1'b0, ser_ready = 1'b1;
  logic [7:0] bus_q, bus_oe;
  logic       rdy, overrun, ser_data, ser_valid;

  always #2 clk = ~clk;

  cfg_byte_loader i_cfg_byte_loader (
    .clk(clk), .rst_n(rst_n), .bus_d_in(bus_d_in), .cs_n(cs_n), .cs(cs),
    .wr_n(wr_n), .rd_n(rd_n), .mirror_en(mirror_en), .bus_q(bus_q),
    .bus_oe(bus_oe), .rdy(rdy), .overrun(overrun), .ser_data(ser_data),
    .ser_valid(ser_valid), .ser_ready(ser_ready)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0, rand_ready = 0;
  logic [7:0] rx_mem [0:127];
  logic [7:0] exp_mem [0:127];
  int rx_n = 0, exp_n = 0, rx_bits = 0, beats = 0, last_acc = -10;
  int stall_err = 0, oe_err = 0;
  logic [7:0] rx_sh = 8'h00;
  logic stall_q = 1'b0, stall_d = 1'b0;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // serial monitor: rebuild bytes, track stalls
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (stall_q && !(ser_valid && ser_data == stall_d)) stall_err++;
      stall_q = ser_valid && !ser_ready;
      stall_d = ser_data;
      if (ser_valid && ser_ready) begin
        beats++;
        last_acc = cyc;
        rx_sh = {rx_sh[6:0], ser_data};
        rx_bits++;
        if (rx_bits == 8) begin
          rx_mem[rx_n[6:0]] = rx_sh;
          rx_n++;
          rx_bits = 0;
        end
      end
    end else begin
      stall_q = 1'b0;
      rx_bits = 0;
    end
  end

  always @(negedge clk) if (rst_n && bus_oe[6:0] != 7'd0) oe_err++;

  initial forever begin
    @(negedge clk);
    ser_ready = rand_ready ? ($urandom % 4 != 0) : 1'b1;
  end

  // one host write; reports whether rdy was ever seen low
  task automatic host_write(input logic [7:0] b, input bit sel, input bit wait_rdy,
                            input bit mir, input bit toggle, output bit saw_low);
    int g;
    saw_low = 0;
    if (wait_rdy) begin
      g = 0;
      while (!rdy && g < 2000) begin @(negedge clk); g++; end
    end
    @(negedge clk);
    bus_d_in = b; mirror_en = mir;
    if (sel) begin cs_n = 1'b0; cs = 1'b1; end
    else if ($urandom % 2 == 0) begin cs_n = 1'b1; cs = 1'b1; end
    else begin cs_n = 1'b0; cs = 1'b0; end
    wr_n = 1'b0;
    repeat (4) begin @(negedge clk); if (!rdy) saw_low = 1; end
    wr_n = 1'b1;
    if (toggle || !sel) begin cs_n = 1'b1; cs = 1'b0; end
    repeat (2) begin @(negedge clk); if (!rdy) saw_low = 1; end
  endtask

  task automatic drain();
    int g = 0;
    while (rx_n != exp_n && g < 20000) begin @(negedge clk); g++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    bit lo;
    bit lowmask [1:6];
    int b0, g;
    void'($urandom(32'h1F3A_5EED));

    repeat (3) @(negedge clk);
    // R10: reset state
    check(rdy === 1'b1, "R10", "rdy in reset", rdy, 1);
    check(overrun === 1'b0 && ser_valid === 1'b0, "R10", "overrun/valid in reset",
          {overrun, ser_valid}, 0);
    check(bus_oe === 8'h00, "R10", "bus_oe in reset", bus_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: short busy with idle shift register
    @(negedge clk);
    bus_d_in = 8'hA5; mirror_en = 0; cs_n = 0; cs = 1; wr_n = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      lowmask[i] = !rdy;
      if (i == 4) wr_n = 1'b1;
    end
    exp_mem[exp_n[6:0]] = 8'hA5; exp_n++;
    check(lowmask[3] == 1'b1, "R3", "rdy low after third edge", !lowmask[3], 0);
    check(!lowmask[1] && !lowmask[2] && !lowmask[4] && !lowmask[5] && !lowmask[6],
          "R3", "rdy low only one cycle",
          {lowmask[1], lowmask[2], lowmask[4], lowmask[5], lowmask[6]}, 0);
    drain();
    check(rx_n == 1 && rx_mem[0] == 8'hA5, "R2", "first byte msb first", rx_mem[0], 8'hA5);

    // R1: deselected write ignored
    host_write(8'h3C, 0, 1, 0, 0, lo);
    repeat (60) @(negedge clk);
    check(!lo, "R1", "rdy stays high on deselected write", lo, 0);
    check(rx_n == exp_n, "R1", "no byte from deselected write", rx_n, exp_n);

    // R6: readback with shift idle, and with a select off
    cs_n = 0; cs = 1; rd_n = 0;
    @(negedge clk);
    check(bus_oe === 8'h80 && bus_q[7] === 1'b1, "R6", "readback ready",
          {bus_oe, bus_q[7]}, {8'h80, 1'b1});
    cs = 0;
    @(negedge clk);
    check(bus_oe === 8'h00, "R6", "no drive when deselected", bus_oe, 0);
    rd_n = 1; cs_n = 1;

    // R4/R5: long busy and overrun, sink always ready
    b0 = beats;
    host_write(8'h81, 1, 1, 0, 0, lo);
    exp_mem[exp_n[6:0]] = 8'h81; exp_n++;
    @(negedge clk);
    bus_d_in = 8'h5A; cs_n = 0; cs = 1; wr_n = 0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (i == 3) check(!rdy, "R4", "busy while shift occupied", rdy, 0);
    end
    wr_n = 1;
    exp_mem[exp_n[6:0]] = 8'h5A; exp_n++;
    repeat (2) @(negedge clk);
    host_write(8'hEE, 1, 0, 0, 0, lo);  // dropped
    check(overrun === 1'b1, "R5", "overrun set by write while busy", overrun, 1);
    rd_n = 0;
    @(negedge clk);
    check(bus_oe === 8'h80 && bus_q[7] === 1'b0, "R6", "readback busy",
          {bus_oe, bus_q[7]}, {8'h80, 1'b0});
    rd_n = 1;
    g = 0;
    while (!rdy && g < 2000) begin @(negedge clk); g++; end
    check(beats - b0 == 8, "R4", "beats of first byte when ready", beats - b0, 8);
    check(cyc == last_acc + 1, "R4", "ready one edge after last beat", cyc, last_acc + 1);
    drain();
    check(overrun === 1'b1, "R5", "overrun sticky", overrun, 1);

    // R8: mirrored byte
    host_write(8'h13, 1, 1, 1, 1, lo);
    exp_mem[exp_n[6:0]] = rev8(8'h13); exp_n++;
    drain();
    check(rx_mem[(rx_n - 1) & 127] == 8'hC8, "R8", "mirrored byte",
          rx_mem[(rx_n - 1) & 127], 8'hC8);

    // random phase: R1 R2 R8 R9 under back-pressure
    rand_ready = 1;
    for (int k = 0; k < 30; k++) begin
      logic [7:0] b;
      bit sel, mir, tog;
      b = 8'($urandom);
      sel = ($urandom % 6 != 0);
      mir = $urandom % 2;
      tog = $urandom % 2;
      host_write(b, sel, 1, mir, tog, lo);
      if (sel) begin
        exp_mem[exp_n[6:0]] = mir ? rev8(b) : b;
        exp_n++;
      end
    end
    drain();
    rand_ready = 0;
    check(rx_n == exp_n, "R2", "byte count", rx_n, exp_n);
    for (int k = 0; k < exp_n && k < 128; k++)
      check(rx_mem[k] == exp_mem[k], "R2", "stream byte", rx_mem[k], exp_mem[k]);
    check(stall_err == 0, "R9", "valid/data held while stalled", stall_err, 0);
    check(oe_err == 0, "R7", "low data lines never driven", oe_err, 0);

    // R10: reset clears sticky overrun
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check(overrun === 1'b0 && rdy === 1'b1, "R10", "reset clears overrun",
          {overrun, rdy}, 2'b01);
    rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule